// File: doc/BRIEF.md
# Event Counter Bank with Privilege-Gated Reads

A bank of 48-bit event counters built from a set of general-purpose counters and a set of fixed counters. Each general-purpose counter has its own 64-bit event-select register; the fixed counters share one 64-bit fixed-control register. Counters step by one on their own event strobe while enabled, wrap to zero past the top value, and can be loaded directly. A register port with a 6-bit address writes and reads back every control register and counter.

A separate counter-read port takes a counter index and a 2-bit privilege level (0 is the most privileged) and returns the count one clock later. A level-0 requester always gets the value. A requester at any other level gets an error when the global user-read enable is clear. Each counter also has its own user-read-disable bit; when set, a lower-privilege read returns zero with no error. A read-only capability word reports that per-counter disable is present.

Top module: `pmc_bank`

## Requirements
- R1: After reset every event-select register, counter, the fixed-control register and the global control register read as zero, and rd_valid_o is low.
- R2: General-purpose counter i increments by one on a cycle with gp_evt_i[i] high while bit 22 of its event-select register is set, and otherwise holds its value.
- R3: Fixed counter i increments by one on a cycle with fix_evt_i[i] high while its enable field, fixed-control bits [4i+3:4i], is nonzero, and otherwise holds.
- R4: Counters are 48 bits wide and step from 2^48-1 to zero.
- R5: A register write to a counter address loads bits [47:0] of the write data; a write wins over an event strobe in the same cycle.
- R6: A read request sampled on a clock edge produces rd_valid_o high with the result for exactly the following cycle; with no request rd_valid_o is low.
- R7: A read at privilege level 0 with an index in range returns the counter value with no error, whatever the enable and disable bits hold.
- R8: A read at levels 1 to 3 while bit 0 of the global control register is clear returns rd_err_o high and data zero.
- R9: A read at levels 1 to 3 with the global enable set returns zero with no error when bit 37 of the counter's event-select register is set, otherwise the counter value.
- R10: Fixed counter i has its user-read-disable bit at fixed-control bit 33+4i and follows the rule of R9 with that bit.
- R11: Index bit 3 selects the fixed group (1) over the general-purpose group (0), bits [2:0] pick the counter; an index past the group's count gives rd_err_o high with data zero at any level.
- R12: The capability word at address 0x22 reads 0x4 (bit 2 reports per-counter read disable) and writes to it are ignored.
- R13: Address map: event-select i at 0x00+i, general counter i at 0x10+i, fixed control at 0x20, global control at 0x21, fixed counter i at 0x30+i; all other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 6 | Register port address |
| reg_wdata_i | input | 64 | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i |
| gp_evt_i | input | NUM_GP | Event strobes, general-purpose counters |
| fix_evt_i | input | NUM_FIX | Event strobes, fixed counters |
| rd_req_i | input | 1 | Counter read request |
| rd_idx_i | input | IDX_W | Counter index, top bit selects group |
| rd_cpl_i | input | 2 | Requester privilege level, 0 most privileged |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | CNT_W | Read result data |
| rd_err_o | output | 1 | Read refused |

## Verification
The assertions assume inputs that are known after reset and that a counter is not written and checked for a step in the same cycle; the properties on each counter condition on the write strobe, so the stimulus may mix writes and events freely. The random phase draws register writes across the whole address space, including unmapped and read-only addresses, and read indices across all 16 codes and all four privilege levels, so fault, zero and pass outcomes all occur. Event-select and fixed-control values are drawn so enable and disable bits change state often.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_EVSEL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_GPCNT  = 6'h10;
  localparam logic [ADDR_W-1:0] A_FIXCTL = 6'h20;
  localparam logic [ADDR_W-1:0] A_GLBCTL = 6'h21;
  localparam logic [ADDR_W-1:0] A_CAPS   = 6'h22;
  localparam logic [ADDR_W-1:0] A_FIXCNT = 6'h30;

  localparam int unsigned ES_EN_BIT   = 22;
  localparam int unsigned ES_URD_BIT  = 37;
  localparam int unsigned FC_EN_W     = 4;
  localparam int unsigned FC_URD_BASE = 33;
  localparam int unsigned FC_STRIDE   = 4;
  localparam int unsigned CAP_URD_BIT = 2;

  typedef enum logic [1:0] {
    RD_PASS  = 2'd0,
    RD_ZERO  = 2'd1,
    RD_FAULT = 2'd2
  } rd_verdict_e;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i) |=> cnt_o == $past(cnt_o) + W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_o)); // R3
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wdata_i)); // R5
endmodule

// File: rtl/pmc_read_gate.sv
module pmc_read_gate
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_GP  = 6,
  parameter int unsigned NUM_FIX = 4,
  parameter int unsigned W       = 48,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [1:0]                    cpl_i,
  input  logic                          usr_en_i,
  input  logic [NUM_GP-1:0][W-1:0]      gp_cnt_i,
  input  logic [NUM_FIX-1:0][W-1:0]     fix_cnt_i,
  input  logic [NUM_GP-1:0]             gp_urd_i,
  input  logic [NUM_FIX-1:0]            fix_urd_i,
  output logic                          valid_o,
  output logic [W-1:0]                  data_o,
  output logic                          err_o
);
  localparam int unsigned SUB_W = IDX_W - 1;

  logic             is_fix;
  logic [SUB_W-1:0] sub;
  logic             in_range;
  logic [W-1:0]     sel_val;
  logic             sel_urd;
  rd_verdict_e      verdict;

  assign is_fix = idx_i[IDX_W-1];
  assign sub    = idx_i[SUB_W-1:0];

  always_comb begin
    in_range = 1'b0;
    sel_val  = '0;
    sel_urd  = 1'b0;
    if (is_fix) begin
      for (int i = 0; i < NUM_FIX; i++) begin
        if (int'(sub) == i) begin
          in_range = 1'b1;
          sel_val  = fix_cnt_i[i];
          sel_urd  = fix_urd_i[i];
        end
      end
    end else begin
      for (int i = 0; i < NUM_GP; i++) begin
        if (int'(sub) == i) begin
          in_range = 1'b1;
          sel_val  = gp_cnt_i[i];
          sel_urd  = gp_urd_i[i];
        end
      end
    end
  end

  // privilege 0 bypasses both user controls
  always_comb begin
    if (!in_range)           verdict = RD_FAULT;
    else if (cpl_i == 2'd0)  verdict = RD_PASS;
    else if (!usr_en_i)      verdict = RD_FAULT;
    else if (sel_urd)        verdict = RD_ZERO;
    else                     verdict = RD_PASS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        data_o <= (verdict == RD_PASS) ? sel_val : '0;
        err_o  <= (verdict == RD_FAULT);
      end
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R6
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R6
  AST_PRIV_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cpl_i == 2'd0 && in_range) |=> !err_o); // R7
  AST_USR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cpl_i != 2'd0 && !usr_en_i) |=> (err_o && data_o == '0)); // R8
  AST_BAD_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !in_range) |=> (err_o && data_o == '0)); // R11
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_GP  = 6,
  parameter int unsigned NUM_FIX = 4,
  parameter int unsigned CNT_W   = 48,
  localparam int unsigned GP_SW  = (NUM_GP  > 1) ? $clog2(NUM_GP)  : 1,
  localparam int unsigned FX_SW  = (NUM_FIX > 1) ? $clog2(NUM_FIX) : 1,
  localparam int unsigned IDX_W  = ((GP_SW > FX_SW) ? GP_SW : FX_SW) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  input  logic                 reg_we_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_GP-1:0]    gp_evt_i,
  input  logic [NUM_FIX-1:0]   fix_evt_i,
  input  logic                 rd_req_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  logic [1:0]           rd_cpl_i,
  output logic                 rd_valid_o,
  output logic [CNT_W-1:0]     rd_data_o,
  output logic                 rd_err_o
);
  logic [NUM_GP-1:0][REG_W-1:0]  evsel_q;
  logic [REG_W-1:0]              fixctl_q;
  logic                          usr_en_q;
  logic [NUM_GP-1:0][CNT_W-1:0]  gp_cnt;
  logic [NUM_FIX-1:0][CNT_W-1:0] fix_cnt;
  logic [NUM_GP-1:0]             gp_urd;
  logic [NUM_FIX-1:0]            fix_urd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fixctl_q <= '0;
      usr_en_q <= 1'b0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_FIXCTL) fixctl_q <= reg_wdata_i;
      if (reg_addr_i == A_GLBCTL) usr_en_q <= reg_wdata_i[0];
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic es_wr, cnt_wr;
    assign es_wr  = reg_we_i && (reg_addr_i == A_EVSEL + ADDR_W'(g));
    assign cnt_wr = reg_we_i && (reg_addr_i == A_GPCNT + ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    evsel_q[g] <= '0;
      else if (es_wr) evsel_q[g] <= reg_wdata_i;
    end

    assign gp_urd[g] = evsel_q[g][ES_URD_BIT];

    pmc_counter #(.W(CNT_W)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cnt_wr),
      .wdata_i (reg_wdata_i[CNT_W-1:0]),
      .inc_i   (gp_evt_i[g] && evsel_q[g][ES_EN_BIT]),
      .cnt_o   (gp_cnt[g])
    );
  end

  for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
    logic cnt_wr;
    assign cnt_wr     = reg_we_i && (reg_addr_i == A_FIXCNT + ADDR_W'(f));
    assign fix_urd[f] = fixctl_q[FC_URD_BASE + FC_STRIDE*f];

    pmc_counter #(.W(CNT_W)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cnt_wr),
      .wdata_i (reg_wdata_i[CNT_W-1:0]),
      .inc_i   (fix_evt_i[f] && (|fixctl_q[FC_EN_W*f +: FC_EN_W])),
      .cnt_o   (fix_cnt[f])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_FIXCTL) reg_rdata_o = fixctl_q;
    if (reg_addr_i == A_GLBCTL) reg_rdata_o = REG_W'(usr_en_q);
    if (reg_addr_i == A_CAPS)   reg_rdata_o = REG_W'(1) << CAP_URD_BIT;
    for (int i = 0; i < NUM_GP; i++) begin
      if (reg_addr_i == A_EVSEL + ADDR_W'(i)) reg_rdata_o = evsel_q[i];
      if (reg_addr_i == A_GPCNT + ADDR_W'(i)) reg_rdata_o = REG_W'(gp_cnt[i]);
    end
    for (int i = 0; i < NUM_FIX; i++) begin
      if (reg_addr_i == A_FIXCNT + ADDR_W'(i)) reg_rdata_o = REG_W'(fix_cnt[i]);
    end
  end

  pmc_read_gate #(
    .NUM_GP  (NUM_GP),
    .NUM_FIX (NUM_FIX),
    .W       (CNT_W),
    .IDX_W   (IDX_W)
  ) i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (rd_req_i),
    .idx_i     (rd_idx_i),
    .cpl_i     (rd_cpl_i),
    .usr_en_i  (usr_en_q),
    .gp_cnt_i  (gp_cnt),
    .fix_cnt_i (fix_cnt),
    .gp_urd_i  (gp_urd),
    .fix_urd_i (fix_urd),
    .valid_o   (rd_valid_o),
    .data_o    (rd_data_o),
    .err_o     (rd_err_o)
  );

  AST_GLB_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_GLBCTL) |=> usr_en_q == $past(reg_wdata_i[0])); // R13
  AST_ERR_NODATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_err_o) |-> rd_data_o == '0); // R8
endmodule

// File: tb/test_pmc_bank.sv
`timescale 1ns/1ps
module test_pmc_bank;
  localparam int NG = 6;
  localparam int NF = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [63:0] reg_rdata;
  logic [NG-1:0] gp_evt = '0;
  logic [NF-1:0] fix_evt = '0;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [1:0]  rd_cpl = '0;
  logic        rd_valid;
  logic [47:0] rd_data;
  logic        rd_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pmc_bank i_pmc_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we), .reg_rdata_o(reg_rdata),
    .gp_evt_i(gp_evt), .fix_evt_i(fix_evt),
    .rd_req_i(rd_req), .rd_idx_i(rd_idx), .rd_cpl_i(rd_cpl),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_err_o(rd_err)
  );

  // reference model
  logic [63:0] m_es [NG];
  logic [47:0] m_gp [NG];
  logic [47:0] m_fx [NF];
  logic [63:0] m_fc;
  logic        m_ge;
  logic        e_v, e_e;
  logic [47:0] e_d;

  function automatic logic [48:0] m_read(input logic [3:0] idx, input logic [1:0] cpl);
    int s = int'(idx[2:0]);
    logic [47:0] v;
    logic urd;
    if (idx[3] ? (s >= NF) : (s >= NG)) return {1'b1, 48'd0};
    v   = idx[3] ? m_fx[s] : m_gp[s];
    urd = idx[3] ? m_fc[33 + 4*s] : m_es[s][37];
    if (cpl == 0) return {1'b0, v};
    if (!m_ge) return {1'b1, 48'd0};
    if (urd) return {1'b0, 48'd0};
    return {1'b0, v};
  endfunction

  function automatic logic [63:0] m_reg(input logic [5:0] a);
    if (a < NG) return m_es[a];
    if (a >= 6'h10 && a < 6'h10 + NG) return {16'd0, m_gp[a - 6'h10]};
    if (a == 6'h20) return m_fc;
    if (a == 6'h21) return {63'd0, m_ge};
    if (a == 6'h22) return 64'h4;
    if (a >= 6'h30 && a < 6'h30 + NF) return {16'd0, m_fx[a - 6'h30]};
    return 64'd0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NG; i++) begin m_es[i] = '0; m_gp[i] = '0; end
      for (int i = 0; i < NF; i++) m_fx[i] = '0;
      m_fc = '0; m_ge = 0; e_v = 0; e_e = 0; e_d = '0;
    end else begin
      e_v = rd_req;
      if (rd_req) {e_e, e_d} = m_read(rd_idx, rd_cpl);
      for (int i = 0; i < NG; i++) begin
        if (reg_we && reg_addr == 6'h10 + i) m_gp[i] = reg_wdata[47:0];
        else if (gp_evt[i] && m_es[i][22]) m_gp[i] = m_gp[i] + 48'd1;
      end
      for (int i = 0; i < NF; i++) begin
        if (reg_we && reg_addr == 6'h30 + i) m_fx[i] = reg_wdata[47:0];
        else if (fix_evt[i] && (m_fc[4*i +: 4] != 0)) m_fx[i] = m_fx[i] + 48'd1;
      end
      if (reg_we) begin
        if (reg_addr < NG) m_es[reg_addr] = reg_wdata;
        if (reg_addr == 6'h20) m_fc = reg_wdata;
        if (reg_addr == 6'h21) m_ge = reg_wdata[0];
      end
    end
  end

  // per-cycle compare of the read port
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      total++;
      if (rd_valid !== e_v || (e_v && (rd_data !== e_d || rd_err !== e_e))) begin
        bad++;
        $display("FAIL R6 R7 R8 R9 R10 R11 read port: got v=%0b d=%0h e=%0b exp v=%0b d=%0h e=%0b",
                 rd_valid, rd_data, rd_err, e_v, e_d, e_e);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk_i);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk_i);
    reg_we = 0;
  endtask

  task automatic rchk(input string tag, input logic [5:0] a, input logic [63:0] exp);
    @(negedge clk_i);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    chk({tag, " model"}, reg_rdata, m_reg(a));
  endtask

  task automatic rd(input string tag, input logic [3:0] idx, input logic [1:0] cpl,
                    input logic [47:0] exp_d, input logic exp_e);
    @(negedge clk_i);
    rd_req = 1; rd_idx = idx; rd_cpl = cpl;
    @(negedge clk_i);
    rd_req = 0;
    chk({tag, " valid"}, 64'(rd_valid), 64'd1);
    chk({tag, " data"}, 64'(rd_data), 64'(exp_d));
    chk({tag, " err"}, 64'(rd_err), 64'(exp_e));
    @(negedge clk_i);
    chk("R6 valid drops", 64'(rd_valid), 64'd0);
  endtask

  task automatic pulse_gp(input int i, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); gp_evt[i] = 1;
      @(negedge clk_i); gp_evt[i] = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk("R1 valid", 64'(rd_valid), 64'd0);
    rchk("R1 evsel0", 6'h00, 64'd0);
    rchk("R1 gpcnt0", 6'h10, 64'd0);
    rchk("R1 fixctl", 6'h20, 64'd0);
    rchk("R1 glbctl", 6'h21, 64'd0);
    rchk("R1 fixcnt3", 6'h33, 64'd0);
    // R12 capability word, read only
    rchk("R12 caps", 6'h22, 64'h4);
    wr(6'h22, 64'hFFFF);
    rchk("R12 caps after write", 6'h22, 64'h4);
    rchk("R13 unmapped", 6'h3F, 64'd0);
    // R2 general counter enable
    wr(6'h00, 64'h40_0000);
    rchk("R13 evsel readback", 6'h00, 64'h40_0000);
    pulse_gp(0, 3);
    pulse_gp(1, 2);
    rchk("R2 gp0 counts", 6'h10, 64'd3);
    rchk("R2 gp1 disabled holds", 6'h11, 64'd0);
    // R3 fixed enable field
    wr(6'h20, 64'h20);
    @(negedge clk_i); fix_evt = 4'b0011;
    @(negedge clk_i); fix_evt = 4'b0011;
    @(negedge clk_i); fix_evt = 4'b0000;
    rchk("R3 fix1 counts", 6'h31, 64'd2);
    rchk("R3 fix0 field zero holds", 6'h30, 64'd0);
    // R4 wrap
    wr(6'h10, 64'hFFFF_FFFF_FFFF);
    pulse_gp(0, 1);
    rchk("R4 wrap to zero", 6'h10, 64'd0);
    // R5 write wins over strobe
    wr(6'h02, 64'h40_0000);
    @(negedge clk_i);
    reg_addr = 6'h12; reg_wdata = 64'hABCD_0000_0000_0064; reg_we = 1; gp_evt[2] = 1;
    @(negedge clk_i);
    reg_we = 0; gp_evt[2] = 0;
    rchk("R5 load beats strobe", 6'h12, 64'd100);
    // R7 R8 R9 read gating
    rd("R7 priv read enable clear", 4'b0010, 2'd0, 48'd100, 1'b0);
    rd("R8 user read enable clear", 4'b0010, 2'd3, 48'd0, 1'b1);
    wr(6'h21, 64'h1);
    rd("R9 user read allowed", 4'b0010, 2'd3, 48'd100, 1'b0);
    wr(6'h02, 64'h20_0040_0000);
    rd("R9 user read disabled gives zero", 4'b0010, 2'd1, 48'd0, 1'b0);
    rd("R7 priv read ignores disable", 4'b0010, 2'd0, 48'd100, 1'b0);
    // R10 fixed disable bits
    wr(6'h30, 64'd7);
    wr(6'h31, 64'd55);
    wr(6'h20, 64'h20_0000_0020);
    rd("R10 fix1 disabled", 4'b1001, 2'd2, 48'd0, 1'b0);
    rd("R10 fix0 unaffected", 4'b1000, 2'd2, 48'd7, 1'b0);
    rd("R10 fix1 priv", 4'b1001, 2'd0, 48'd55, 1'b0);
    // R11 index range
    rd("R11 gp index 6", 4'b0110, 2'd0, 48'd0, 1'b1);
    rd("R11 fix index 4", 4'b1100, 2'd3, 48'd0, 1'b1);
    rd("R11 fix index 3", 4'b1011, 2'd0, 48'd0, 1'b0);
    // random phase, per-cycle compare
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk_i);
      gp_evt  = NG'($urandom);
      fix_evt = NF'($urandom);
      rd_req  = $urandom_range(0, 1) == 1;
      rd_idx  = 4'($urandom);
      rd_cpl  = 2'($urandom);
      reg_we  = $urandom_range(0, 3) == 0;
      reg_addr = 6'($urandom);
      reg_wdata = {32'($urandom), 32'($urandom)};
      if ($urandom_range(0, 3) == 0) reg_wdata[47:0] = 48'hFFFF_FFFF_FFFE;
    end
    @(negedge clk_i);
    reg_we = 0; rd_req = 0; gp_evt = '0; fix_evt = '0;
    for (int a = 0; a < 64; a++) rchk("R13 final map", 6'(a), m_reg(6'(a)));
    @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule